// File: doc/BRIEF.md
# Interval timer and interrupt unit with parallel-port register file

This core sits on a small register bus: a 4-bit address, a byte of write data, and separate read and write strobes. It holds two 16-bit down-counting timers and a seven-source interrupt flag and enable pair, and it drives one active-low interrupt request. Around the timers it keeps a full sixteen-slot register file. That file includes two port output bytes, two direction bytes, a shift byte, and an auxiliary and a peripheral control byte. These are plain storage. No handshake or serial shifting is attached to them.

Timer 1 loads its counter from a 16-bit latch when software writes the high byte. It can run once or reload itself, as one control bit selects. Timer 2 is a one-shot counter, started by writing its high byte. A timer loaded with N marks an underflow every N+2 clocks. Two external request inputs set their own flag bits on a rising edge. Any flag that is also enabled pulls the request line low and shows as bit 7 of the flag register.

Top module: `via_timer_core`

## Requirements
- R1: The storage slots hold the last byte written and read it back at the same address: 0 port B, 1 port A (slot 15 is the same byte as slot 1), 2 direction B, 3 direction A, 10 shift, 11 auxiliary control, 12 peripheral control, 6 and 7 timer 1 latch low and high.
- R2: A write to address 4 sets the timer 1 latch low byte, the same byte that address 6 reads. Reads of address 4 and 5 return the live timer 1 counter, low and high byte.
- R3: A write to address 5 sets the latch high byte and loads the counter with {written byte, latch low} on that clock edge. It arms timer 1 and clears the timer 1 flag (flag bit 6).
- R4: With auxiliary bit 6 at 1 (free-running), a counter started with N reads N, N-1, ... 0, then 0xFFFF, then N again. Flag bit 6 is set on every step from 0 to 0xFFFF, so once every N+2 clocks.
- R5: With auxiliary bit 6 at 0 (one-shot), timer 1 sets flag bit 6 only on its first step from 0 to 0xFFFF after a start. The counter then keeps decrementing and wraps without reloading.
- R6: A write to address 8 sets the timer 2 latch low byte. A write to address 9 loads the counter with {written byte, latch low} and arms timer 2. Timer 2 is always one-shot and sets flag bit 5 on its first underflow. Address 8 and 9 read the counter low and high byte.
- R7: A read of address 4 clears flag bit 6, and a read of address 8 or a write of address 9 clears flag bit 5. A flag set and a clear in the same cycle leave the flag set.
- R8: A rising edge on ext_irq_a sets flag bit 1, and a rising edge on ext_irq_b sets flag bit 4. A level held high does not set the flag again after it has been cleared.
- R9: A write to address 13 clears every flag whose written bit (6..0) is 1. Written bit 7 has no effect.
- R10: A write to address 14 with bit 7 at 1 sets the enable bits marked by bits 6..0. With bit 7 at 0 it clears them. Address 14 reads {1, enables}.
- R11: Address 13 reads {summary, flags}, where summary is 1 when any flag bit 6..0 is set together with its enable bit. irq_n is low exactly when summary is 1.
- R12: After reset the flags, enables, auxiliary, peripheral and both direction bytes are 0, irq_n is 1, and neither timer is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe, one access per clock |
| rd_en | input | 1 | Read strobe, side effects on the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| ext_irq_a | input | 1 | External request A, sets flag bit 1 on a rising edge |
| ext_irq_b | input | 1 | External request B, sets flag bit 4 on a rising edge |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
On every cycle the assertions check five things:
- the timer 1 load on a high-byte write, and that the timer 1 flag is clear afterwards;
- the one-step countdown whenever no load or reload occurs;
- the enable set and clear writes;
- that a low request line always has some enable behind it.

Some behaviours only the bench scenarios can show:
- the N+2 reload period and the single flag of a one-shot run, each compared with a per-cycle counter model for random and edge values of N, including N of 0 and 1;
- the edge-only response of the external inputs;
- the clearing of flags by reads.

// File: rtl/via_timer_core.sv
module via_timer_core #(
  parameter int TW = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ext_irq_a,
  input  logic       ext_irq_b,
  output logic       irq_n
);
  localparam logic [TW-1:0] ALL_ONES = '1;

  logic [7:0]    orb, ora, ddrb, ddra, sr, acr, pcr;
  logic [TW-1:0] t1_lat, t1_cnt, t2_cnt;
  logic [7:0]    t2_lat_lo;
  logic          t1_arm, t1_pend, t2_arm;
  logic [6:0]    flags, ier;
  logic          ext_a_q, ext_b_q;

  wire wr_at = wr_en;
  wire t1_load = wr_at && addr == 4'h5;
  wire t2_load = wr_at && addr == 4'h9;
  wire t1_fire = t1_arm && !t1_load && !t1_pend && t1_cnt == '0;
  wire t2_fire = t2_arm && !t2_load && t2_cnt == '0;
  wire a_rise  = ext_irq_a && !ext_a_q;
  wire b_rise  = ext_irq_b && !ext_b_q;
  wire summary = |(flags & ier);

  assign irq_n = ~summary;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      orb <= '0; ora <= '0; ddrb <= '0; ddra <= '0;
      sr <= '0; acr <= '0; pcr <= '0;
    end else if (wr_at) begin
      case (addr)
        4'h0: orb <= wdata;
        4'h1, 4'hF: ora <= wdata;
        4'h2: ddrb <= wdata;
        4'h3: ddra <= wdata;
        4'hA: sr <= wdata;
        4'hB: acr <= wdata;
        4'hC: pcr <= wdata;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      t1_lat <= '0; t1_cnt <= '0; t1_arm <= 1'b0; t1_pend <= 1'b0;
    end else begin
      if (wr_at && (addr == 4'h4 || addr == 4'h6)) t1_lat[7:0] <= wdata;
      if (wr_at && (addr == 4'h5 || addr == 4'h7)) t1_lat[TW-1:8] <= wdata;
      if (t1_load) begin
        t1_cnt  <= {wdata, t1_lat[7:0]};
        t1_arm  <= 1'b1;
        t1_pend <= 1'b0;
      end else if (t1_pend) begin
        t1_cnt  <= t1_lat;
        t1_pend <= 1'b0;
      end else begin
        t1_cnt <= t1_cnt - 1'b1;
        if (t1_cnt == '0) begin
          t1_pend <= acr[6];
          if (!acr[6]) t1_arm <= 1'b0;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      t2_lat_lo <= '0; t2_cnt <= '0; t2_arm <= 1'b0;
    end else begin
      if (wr_at && addr == 4'h8) t2_lat_lo <= wdata;
      if (t2_load) begin
        t2_cnt <= {wdata, t2_lat_lo};
        t2_arm <= 1'b1;
      end else begin
        t2_cnt <= t2_cnt - 1'b1;
        if (t2_cnt == '0) t2_arm <= 1'b0;
      end
    end

  logic [6:0] set_v, clr_v;
  always_comb begin
    set_v = {t1_fire, t2_fire, b_rise, 2'b00, a_rise, 1'b0};
    clr_v = (wr_at && addr == 4'hD) ? wdata[6:0] : 7'h00;
    if ((rd_en && addr == 4'h4) || t1_load) clr_v[6] = 1'b1;
    if ((rd_en && addr == 4'h8) || t2_load) clr_v[5] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flags <= '0; ier <= '0; ext_a_q <= 1'b0; ext_b_q <= 1'b0;
    end else begin
      ext_a_q <= ext_irq_a;
      ext_b_q <= ext_irq_b;
      flags   <= (flags & ~clr_v) | set_v;
      if (wr_at && addr == 4'hE)
        ier <= wdata[7] ? (ier | wdata[6:0]) : (ier & ~wdata[6:0]);
    end

  always_comb
    case (addr)
      4'h0: rdata = orb;
      4'h1, 4'hF: rdata = ora;
      4'h2: rdata = ddrb;
      4'h3: rdata = ddra;
      4'h4: rdata = t1_cnt[7:0];
      4'h5: rdata = t1_cnt[TW-1:8];
      4'h6: rdata = t1_lat[7:0];
      4'h7: rdata = t1_lat[TW-1:8];
      4'h8: rdata = t2_cnt[7:0];
      4'h9: rdata = t2_cnt[TW-1:8];
      4'hA: rdata = sr;
      4'hB: rdata = acr;
      4'hC: rdata = pcr;
      4'hD: rdata = {summary, flags};
      default: rdata = {1'b1, ier};
    endcase

  wire unused_ok = &{1'b0, ALL_ONES[0]};
endmodule

// File: rtl/via_timer_core_sva.sv
module via_timer_core_sva (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  addr,
  input logic        wr_en,
  input logic [7:0]  wdata,
  input logic        irq_n,
  input logic [15:0] t1_cnt,
  input logic [15:0] t1_lat,
  input logic        t1_pend,
  input logic        t1_flag,
  input logic [6:0]  ier
);
  assert_t1_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h5) |=> t1_cnt == {$past(wdata), $past(t1_lat[7:0])});

  assert_t1_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h5) |=> !t1_flag);

  assert_t1_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && addr == 4'h5) && !t1_pend) |=> t1_cnt == $past(t1_cnt) - 16'd1);

  assert_ier_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'hE && wdata[7]) |=> (ier & $past(wdata[6:0])) == $past(wdata[6:0]));

  assert_ier_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'hE && !wdata[7]) |=> (ier & $past(wdata[6:0])) == 7'h00);

  assert_irq_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> ier != 7'h00);
endmodule

bind via_timer_core via_timer_core_sva u_sva (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .irq_n(irq_n), .t1_cnt(t1_cnt), .t1_lat(t1_lat), .t1_pend(t1_pend),
  .t1_flag(flags[6]), .ier(ier)
);

// File: tb/via_timer_core_test.sv
module via_timer_core_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, wr_en, rd_en, ext_irq_a, ext_irq_b, irq_n;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  via_timer_core uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .ext_irq_a(ext_irq_a), .ext_irq_b(ext_irq_b),
    .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  function automatic logic [15:0] exp_cnt(int n, int j, bit free);
    int p;
    if (!free) return 16'(n - j);
    p = j % (n + 2);
    return (p <= n) ? 16'(n - p) : 16'hFFFF;
  endfunction

  function automatic bit exp_uf(int n, int j, bit free);
    if (j < 1) return 1'b0;
    if (!free) return j == n + 1;
    return (j >= n + 1) && ((j - (n + 1)) % (n + 2) == 0);
  endfunction

  task automatic run_timer(input int which, input int n, input bit free, input string req);
    logic [3:0] lo_a = (which == 1) ? 4'h4 : 4'h8;
    logic [3:0] hi_a = (which == 1) ? 4'h5 : 4'h9;
    logic [7:0] en   = (which == 1) ? 8'h40 : 8'h20;
    logic [15:0] nv  = 16'(n);
    wr(4'hB, free ? 8'h40 : 8'h00);
    wr(4'hE, 8'h7F);
    wr(4'hE, 8'h80 | en);
    wr(4'hD, 8'h7F);
    wr(lo_a, nv[7:0]);
    wr(hi_a, nv[15:8]);
    addr = lo_a; rd_en = 1'b1;
    for (int k = 1; k <= 3 * (n + 2); k++) begin
      @(negedge clk);
      chk({req, " count"}, rdata, exp_cnt(n, k - 1, free) & 16'hFF);
      chk({req, " R7 flag"}, irq_n, !exp_uf(n, k - 1, free));
    end
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] shadow [16];
    logic [3:0] slots [10] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h6, 4'h7, 4'hA, 4'hB, 4'hC, 4'hF};
    process::self().srandom(32'd1234);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; ext_irq_a = 1'b0; ext_irq_b = 1'b0;
    addr = 4'h0; wdata = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12 reset state
    chk("R12 irq_n", irq_n, 1);
    rd(4'hD, d); chk("R12 flags", d, 8'h00);
    rd(4'hE, d); chk("R12 enables", d, 8'h80);
    rd(4'hB, d); chk("R12 aux", d, 8'h00);
    rd(4'hC, d); chk("R12 periph", d, 8'h00);
    rd(4'h2, d); chk("R12 dir B", d, 8'h00);
    rd(4'h3, d); chk("R12 dir A", d, 8'h00);
    repeat (20) @(posedge clk);
    rd(4'hD, d); chk("R12 timers idle", d, 8'h00);

    // R1 random storage readback
    for (int i = 0; i < 30; i++) begin
      logic [3:0] a = slots[$urandom_range(9)];
      logic [7:0] v = 8'($urandom);
      wr(a, v);
      shadow[a] = v;
      rd(a, d); chk("R1 readback", d, v);
      if (a == 4'h1 || a == 4'hF) begin
        rd((a == 4'h1) ? 4'hF : 4'h1, d); chk("R1 port A alias", d, v);
      end
    end

    // R2 write 4 shares latch low with address 6
    wr(4'h4, 8'hC3); rd(4'h6, d); chk("R2 latch low", d, 8'hC3);

    // R4 free-running, directed and random N
    run_timer(1, 0, 1'b1, "R4");
    run_timer(1, 1, 1'b1, "R4");
    for (int i = 0; i < 4; i++) run_timer(1, $urandom_range(2, 20), 1'b1, "R4");
    // R5 one-shot
    run_timer(1, 0, 1'b0, "R5");
    for (int i = 0; i < 4; i++) run_timer(1, $urandom_range(1, 20), 1'b0, "R5");
    // R6 timer 2
    run_timer(2, 1, 1'b0, "R6");
    for (int i = 0; i < 3; i++) run_timer(2, $urandom_range(2, 20), 1'b0, "R6");

    // R3 high-byte write clears the timer 1 flag
    wr(4'hE, 8'h7F); wr(4'hE, 8'hC0);
    wr(4'h4, 8'h02); wr(4'h5, 8'h00);
    repeat (8) @(posedge clk);
    rd(4'hD, d); chk("R3 flag set before", d, 8'hC0);
    wr(4'h4, 8'h00); wr(4'h5, 8'h01);
    rd(4'hD, d); chk("R3 flag cleared by start", d, 8'h00);
    rd(4'h5, d); chk("R2 counter high", d, 8'h00);

    // R8 external edges, R9 flag clear, R10 enables, R11 summary
    wr(4'hE, 8'h7F);
    @(negedge clk); ext_irq_a = 1'b1;
    @(negedge clk);
    rd(4'hD, d); chk("R8 ext A flag", d, 8'h02);
    chk("R11 masked irq_n", irq_n, 1);
    wr(4'hE, 8'h82);
    rd(4'hE, d); chk("R10 enable read", d, 8'h82);
    rd(4'hD, d); chk("R11 summary", d, 8'h82);
    chk("R11 irq_n low", irq_n, 0);
    wr(4'hD, 8'h80);
    rd(4'hD, d); chk("R9 bit 7 ignored", d, 8'h82);
    wr(4'hD, 8'h02);
    rd(4'hD, d); chk("R9 clear", d, 8'h00);
    chk("R11 irq_n released", irq_n, 1);
    repeat (4) @(posedge clk);
    rd(4'hD, d); chk("R8 level no reset", d, 8'h00);
    @(negedge clk); ext_irq_a = 1'b0; ext_irq_b = 1'b1;
    @(negedge clk); ext_irq_b = 1'b0;
    rd(4'hD, d); chk("R8 ext B flag", d, 8'h10);
    wr(4'hE, 8'h02);
    rd(4'hE, d); chk("R10 enable clear", d, 8'h80);
    wr(4'hE, 8'h90);
    chk("R11 ext B irq_n", irq_n, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule